// File: doc/BRIEF.md
# Guarded Target Address Register

This block holds the slave address that a bus master will call next, together with a flag that chooses 10-bit or 7-bit addressing for those master transfers. Software writes both fields through one register word. The block decides on the spot whether a write may land, using the controller's live state in the same cycle as the write strobe.

When the controller is switched off, a write always lands. When the controller is running, a write lands only if master mode is configured, no master transmit or receive is in progress, and the transmit queue is empty. Any other write is dropped, the stored fields keep their values, and a one-cycle pulse reports the drop. The stored word is always available for readback, and the unused bit positions in it read as zero. The bus engine that uses the address and the transmit queue are outside this block. This block only sees the queue's empty flag and the activity flag.

Top module: `guarded_tar`

## Requirements
- R1: After reset the address output is 0, the mode flag is 0 (7-bit addressing), the drop pulse is 0 and the readback word is 0.
- R2: A write with the controller enable at 0 is accepted whatever the other status inputs are. On the next cycle the address equals write data bits 9:0 and the mode flag equals write data bit 12.
- R3: A write with enable at 1 is accepted when master mode is 1, master activity is 0 and transmit-empty is 1.
- R4: A write with enable at 1 is dropped if master activity is 1, or master mode is 0, or transmit-empty is 0. Address and mode flag keep their values.
- R5: A dropped write raises the drop pulse during exactly the one cycle that follows the write. The pulse is 0 after accepted writes and after cycles with no write.
- R6: The readback word carries the address in bits 9:0 and the mode flag in bit 12. Bits 11:10 and 31:13 read as 0.
- R7: Write data bits 11:10 and 31:13 have no effect on the stored fields or on the readback word.
- R8: The accept or drop decision uses the status input values in the cycle where the write strobe is high. Status values in the neighbouring cycles do not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| ctl_enable | input | 1 | Controller enable bit |
| cfg_master | input | 1 | Master mode configured |
| mst_busy | input | 1 | Master transmit or receive in progress |
| txq_empty | input | 1 | Transmit queue holds no entries |
| tgt_addr | output | 10 | Stored target address |
| addr10_sel | output | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| wr_dropped | output | 1 | One-cycle pulse after a dropped write |
| rd_word | output | 32 | Readback word |

## Verification
Two things can happen in the same cycle: a write strobe, and a change of a status input such as master activity rising or the queue filling. The bench places status changes in the cycle of the strobe and in the cycles on either side of it. It then judges the accept or drop decision only against the status seen in the strobe cycle. It also runs two dropped writes back to back, so that one drop pulse must end exactly as the next begins. The bench sweeps all sixteen status combinations against several data patterns and compares each result with an arithmetic model.

// File: rtl/guarded_tar_pkg.sv
package guarded_tar_pkg;
  parameter int WORD_W   = 32;
  parameter int ADDR_W   = 10;
  parameter int MODE_POS = 12;

  localparam logic [WORD_W-1:0] ADDR_MASK = (WORD_W'(1) << ADDR_W) - WORD_W'(1);
  localparam logic [WORD_W-1:0] MODE_MASK = WORD_W'(1) << MODE_POS;
  localparam logic [WORD_W-1:0] KEEP_MASK = ADDR_MASK | MODE_MASK;

  typedef struct packed {
    logic ctl_enable;
    logic cfg_master;
    logic mst_busy;
    logic txq_empty;
  } ctl_state_t;
endpackage

// File: rtl/guarded_tar_rst_sync.sv
module guarded_tar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/guarded_tar_gate.sv
module guarded_tar_gate
  import guarded_tar_pkg::*;
(
  input  logic       wr_stb,
  input  ctl_state_t st,
  output logic       wr_take,
  output logic       wr_drop
);
  logic idle_master;

  always_comb begin
    idle_master = st.cfg_master & ~st.mst_busy & st.txq_empty;
    wr_take     = wr_stb & (~st.ctl_enable | idle_master);
    wr_drop     = wr_stb & st.ctl_enable & ~idle_master;
  end
endmodule

// File: rtl/guarded_tar_store.sv
module guarded_tar_store
  import guarded_tar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_q
);
  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (load) word_d = wr_data & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_d;
  end
endmodule

// File: rtl/guarded_tar.sv
module guarded_tar
  import guarded_tar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ctl_enable,
  input  logic              cfg_master,
  input  logic              mst_busy,
  input  logic              txq_empty,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              addr10_sel,
  output logic              wr_dropped,
  output logic [WORD_W-1:0] rd_word
);
  logic       rst_sync_n;
  logic       wr_take;
  logic       wr_drop;
  logic       drop_d;
  logic       drop_q;
  ctl_state_t st;
  logic [WORD_W-1:0] word_q;

  assign st = '{ctl_enable: ctl_enable, cfg_master: cfg_master,
                mst_busy: mst_busy, txq_empty: txq_empty};

  guarded_tar_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  guarded_tar_gate u_gate (
    .wr_stb(wr_stb), .st(st), .wr_take(wr_take), .wr_drop(wr_drop)
  );

  guarded_tar_store u_store (
    .clk(clk), .rst_n(rst_sync_n), .load(wr_take),
    .wr_data(wr_data), .word_q(word_q)
  );

  always_comb begin
    drop_d = wr_drop;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) drop_q <= 1'b0;
    else             drop_q <= drop_d;
  end

  assign tgt_addr   = word_q[ADDR_W-1:0];
  assign addr10_sel = word_q[MODE_POS];
  assign rd_word    = word_q;
  assign wr_dropped = drop_q;
endmodule

// File: rtl/guarded_tar_chk.sv
module guarded_tar_chk
  import guarded_tar_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_stb,
  input logic [WORD_W-1:0] wr_data,
  input logic              ctl_enable,
  input logic              cfg_master,
  input logic              mst_busy,
  input logic              txq_empty,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              addr10_sel,
  input logic              wr_dropped,
  input logic [WORD_W-1:0] rd_word
);
  logic busy_path;
  assign busy_path = mst_busy | ~cfg_master | ~txq_empty;

  AST_OFF_TAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb && !ctl_enable) |=> (tgt_addr == $past(wr_data[ADDR_W-1:0]) && addr10_sel == $past(wr_data[MODE_POS]))); // R2
  AST_IDLE_TAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb && ctl_enable && !busy_path) |=> (tgt_addr == $past(wr_data[ADDR_W-1:0]) && !wr_dropped)); // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb && ctl_enable && busy_path) |=> ($stable(tgt_addr) && $stable(addr10_sel) && wr_dropped)); // R4
  AST_NO_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_stb |=> (!wr_dropped && $stable(rd_word))); // R5
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_word & ~KEEP_MASK) == '0); // R6
  AST_RD_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_word[ADDR_W-1:0] == tgt_addr && rd_word[MODE_POS] == addr10_sel)); // R6
endmodule

bind guarded_tar guarded_tar_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_stb(wr_stb), .wr_data(wr_data),
  .ctl_enable(ctl_enable), .cfg_master(cfg_master), .mst_busy(mst_busy),
  .txq_empty(txq_empty), .tgt_addr(tgt_addr), .addr10_sel(addr10_sel),
  .wr_dropped(wr_dropped), .rd_word(rd_word)
);

// File: tb/guarded_tar_tb.sv
module guarded_tar_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ctl_enable = 1'b0;
  logic        cfg_master = 1'b0;
  logic        mst_busy = 1'b0;
  logic        txq_empty = 1'b0;
  logic [9:0]  tgt_addr;
  logic        addr10_sel;
  logic        wr_dropped;
  logic [31:0] rd_word;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [9:0] m_addr = '0;
  logic       m_mode = 1'b0;

  always #10 clk = ~clk;

  guarded_tar u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .ctl_enable(ctl_enable), .cfg_master(cfg_master), .mst_busy(mst_busy),
    .txq_empty(txq_empty), .tgt_addr(tgt_addr), .addr10_sel(addr10_sel),
    .wr_dropped(wr_dropped), .rd_word(rd_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word();
    return {19'd0, m_mode, 2'b00, m_addr};
  endfunction

  // Write at a negedge with status s = {enable, master, busy, empty}, then check one cycle later
  task automatic do_write(input logic [3:0] s, input logic [31:0] d, input logic [3:0] s_after);
    logic take;
    {ctl_enable, cfg_master, mst_busy, txq_empty} = s;
    wr_data = d;
    wr_stb  = 1'b1;
    take = !s[3] || (s[2] && !s[1] && s[0]);
    @(negedge clk);
    wr_stb = 1'b0;
    wr_data = ~d;
    {ctl_enable, cfg_master, mst_busy, txq_empty} = s_after; // R8: status changes right after the strobe
    if (take) begin
      m_addr = d[9:0];
      m_mode = d[12];
    end
    if (!s[3]) chk("R2", {22'd0, tgt_addr}, {22'd0, m_addr});
    else if (take) chk("R3", {22'd0, tgt_addr}, {22'd0, m_addr});
    else chk("R4", {22'd0, tgt_addr}, {22'd0, m_addr});
    chk(take ? "R3" : "R4", {31'd0, addr10_sel}, {31'd0, m_mode});
    chk("R5", {31'd0, wr_dropped}, {31'd0, !take});
    chk("R6", rd_word, m_word());
    chk("R7", rd_word & 32'hFFFF_EC00, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF;
    pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5A5_E2B6;
    pats[3] = 32'h5A5A_1D49;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {22'd0, tgt_addr}, 32'd0);
    chk("R1", {31'd0, addr10_sel}, 32'd0);
    chk("R1", {31'd0, wr_dropped}, 32'd0);
    chk("R1", rd_word, 32'd0);

    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 16; s++) begin
        // Refresh with a disabled write so every drop is seen against a known value
        do_write(4'b0000, pats[(p + s) % 4] ^ 32'(s * 97), 4'(~s));
        do_write(4'(s), pats[p] ^ 32'(s * 131), 4'(~s));
        @(negedge clk);
        chk("R5", {31'd0, wr_dropped}, 32'd0);
        chk("R6", rd_word, m_word());
      end
    end

    // R8: status flips in the cycles on either side of the strobe
    {ctl_enable, cfg_master, mst_busy, txq_empty} = 4'b1110;
    @(negedge clk);
    do_write(4'b1101, 32'h0000_13C7, 4'b1110);
    chk("R8", rd_word, 32'h0000_13C7);
    do_write(4'b1111, 32'h0000_0155, 4'b1101);
    chk("R8", rd_word, 32'h0000_13C7);

    // R5: two drops back to back, then quiet
    do_write(4'b1001, 32'h0000_0001, 4'b1001);
    do_write(4'b1100, 32'h0000_0002, 4'b1101);
    @(negedge clk);
    chk("R5", {31'd0, wr_dropped}, 32'd0);
    chk("R7", rd_word, 32'h0000_13C7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule